// File: doc/BRIEF.md
# Host-Loaded Microcode Control Store

This block holds the microcode for a small engine and lets a host load it over a narrow register port. The host sees four 16-bit registers: control/maintenance, status-out, address, and maintenance data. To write a store word it clears the control register, loads the address and data registers, sets the output-store select bit, and then adds the write bit. The store takes the data word on the rising edge of that write bit. To check a word, the host clears control, loads the address and sets the select bit. The maintenance data register then returns the stored word.

After loading, the host sets run and arbitration-enable to start the engine, which sits outside this block. The engine reads the store through its own synchronous port. It reports ready-in and posts status words into the status-out register. Setting the reset bit holds the engine in reset until a write of zero releases it. The in-interrupt output follows ready-in gated by its enable bit. The store depth is a parameter and must be a power of two. Addresses wrap modulo the depth.

Top module: `wcs_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `bus_rdata`, `ctrl_o`, `eng_rst_o` and `irq_in_o` are zero. A read of the control register with `seq_ready_i` low returns 0.
- R2: Register select codes on `bus_sel` are: 0 control, 1 status-out, 2 address, 3 maintenance data. The control register keeps bits 15 run, 14 reset, 13 store write, 11 arbitration enable, 10 output-store select, 9 input-store select, 8 single-step, 6 in-interrupt enable, 3:2 address extension and 0 go (mask 0xEF4D). Other written bits read as 0. Bit 7 reads the live `seq_ready_i`. `ctrl_o` carries the stored bits with bit 7 zero.
- R3: A control write whose value has bit 13 set, bit 10 set and bit 15 clear, while the stored bit 13 is clear, writes the maintenance data register into the store at the address register modulo DEPTH.
- R4: When stored control bit 10 is set, a read of the maintenance data register returns the store word at the current address. When bit 10 is clear, the read returns the last value written to the data register.
- R5: A control write with bit 13 set while the stored bit 13 is already set does not write the store.
- R6: A control write that sets bit 13 with bit 10 clear does not write the store.
- R7: A control write that sets bit 13 together with bit 15 (run) does not write the store.
- R8: Store addressing uses the address register modulo DEPTH. Address DEPTH+5 and address 5 reach the same word.
- R9: `eng_rst_o` is high from the edge after a control write with bit 14 set, and stays high until bit 14 is written clear. While it is high, the status-out register is held at zero.
- R10: `irq_in_o` equals `seq_ready_i` AND control bit 6, both as sampled one clock earlier.
- R11: Status-out layout: bit 15 error, bits 14:13 error status, bits 12:8 error subcode, bit 7 ready-out, bit 6 out-interrupt enable, bits 2:0 user index. A pulse on `sts_load_i` loads `sts_err_i` into bits 15:8 and `sts_uidx_i` into bits 2:0, and sets bit 7. A host write sets bit 6 from the data. The same write can clear bit 7 by writing 0 there, but writing 1 to bit 7 never sets it.
- R12: `seq_data_o` returns the store word at `seq_addr_i` one clock after the address is presented.
- R13: `bus_rdata` updates on the clock edge that samples `bus_rd` and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host register write strobe |
| bus_rd | input | 1 | Host register read strobe |
| bus_sel | input | 2 | Host register select |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Registered host read data |
| seq_ready_i | input | 1 | Engine ready-in flag |
| sts_load_i | input | 1 | Engine status post strobe |
| sts_uidx_i | input | 3 | Engine user index |
| sts_err_i | input | 8 | Engine error byte (error, status, subcode) |
| seq_addr_i | input | AW | Engine store read address |
| seq_data_o | output | 16 | Engine store read data |
| ctrl_o | output | 16 | Stored control bits to the engine |
| eng_rst_o | output | 1 | Engine reset |
| irq_in_o | output | 1 | In-interrupt request |

## Verification
The write path gets four kinds of input. One is the full select-then-strobe sequence. A second repeats the control write with the strobe already high. A third raises the strobe without select. The last raises it together with run. Readback tells these apart, because only the first changes the stored word. A wrapped address aliasing a low one shows the modulo addressing, and the engine port reading the same word shows that both ports see one array. Status posts, host clears with 0 and 1 in bit 7, and the reset hold separate the owners of the status-out fields.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_ADDR = 2'd2,
    REG_MDAT = 2'd3
  } host_reg_e;

  localparam int unsigned CB_RUN  = 15;
  localparam int unsigned CB_RST  = 14;
  localparam int unsigned CB_WRT  = 13;
  localparam int unsigned CB_OSEL = 10;
  localparam int unsigned CB_RDY  = 7;
  localparam int unsigned CB_IIE  = 6;

  localparam int unsigned SB_ROUT = 7;
  localparam int unsigned SB_OIE  = 6;

  localparam logic [WORD_W-1:0] CTRL_KEEP = 16'hEF4D;
endpackage

// File: rtl/wcs_store.sv
module wcs_store #(
  parameter int DEPTH = 1024,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/wcs_host_regs.sv
module wcs_host_regs
  import wcs_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_sel,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              sts_load_i,
  input  logic [2:0]        sts_uidx_i,
  input  logic [7:0]        sts_err_i,
  output logic [WORD_W-1:0] ctrl_q,
  output logic [WORD_W-1:0] addr_q,
  output logic [WORD_W-1:0] data_q,
  output logic [WORD_W-1:0] status_q,
  output logic              st_we,
  output logic [AW-1:0]     st_addr
);
  logic wr_ctrl, wr_stat;
  logic [WORD_W-1:0] status_nxt;

  assign wr_ctrl = bus_wr && (bus_sel == REG_CTRL);
  assign wr_stat = bus_wr && (bus_sel == REG_STAT);

  // store strobe: write bit rising, output-store selected, engine not running
  assign st_we = wr_ctrl && bus_wdata[CB_WRT] && !ctrl_q[CB_WRT]
                 && bus_wdata[CB_OSEL] && !bus_wdata[CB_RUN];
  assign st_addr = addr_q[AW-1:0];

  always_comb begin
    status_nxt = status_q;
    if (wr_stat) begin
      status_nxt[SB_OIE]  = bus_wdata[SB_OIE];
      status_nxt[SB_ROUT] = status_q[SB_ROUT] & bus_wdata[SB_ROUT];
    end
    if (sts_load_i) begin
      status_nxt[15:8]    = sts_err_i;
      status_nxt[SB_ROUT] = 1'b1;
      status_nxt[2:0]     = sts_uidx_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      status_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
      if (bus_wr && bus_sel == REG_ADDR) addr_q <= bus_wdata;
      if (bus_wr && bus_sel == REG_MDAT) data_q <= bus_wdata;
      if (ctrl_q[CB_RST]) status_q <= '0;
      else                status_q <= status_nxt;
    end
  end
endmodule

// File: rtl/wcs_readback.sv
module wcs_readback
  import wcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic [1:0]        bus_sel,
  input  logic              seq_ready_i,
  input  logic [WORD_W-1:0] ctrl_q,
  input  logic [WORD_W-1:0] status_q,
  input  logic [WORD_W-1:0] addr_q,
  input  logic [WORD_W-1:0] data_q,
  input  logic [WORD_W-1:0] ram_q,
  output logic [WORD_W-1:0] bus_rdata
);
  logic [WORD_W-1:0] sel_val;

  always_comb begin
    unique case (host_reg_e'(bus_sel))
      REG_CTRL: begin
        sel_val = ctrl_q & CTRL_KEEP;
        sel_val[CB_RDY] = seq_ready_i;
      end
      REG_STAT: sel_val = status_q;
      REG_ADDR: sel_val = addr_q;
      default:  sel_val = ctrl_q[CB_OSEL] ? ram_q : data_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= sel_val;
  end
endmodule

// File: rtl/wcs_top.sv
module wcs_top
  import wcs_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_sel,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              seq_ready_i,
  input  logic              sts_load_i,
  input  logic [2:0]        sts_uidx_i,
  input  logic [7:0]        sts_err_i,
  input  logic [AW-1:0]     seq_addr_i,
  output logic [WORD_W-1:0] seq_data_o,
  output logic [WORD_W-1:0] ctrl_o,
  output logic              eng_rst_o,
  output logic              irq_in_o
);
  logic [WORD_W-1:0] ctrl_q, addr_q, data_q, status_q, ram_q;
  logic              st_we;
  logic [AW-1:0]     st_addr;
  logic              irq_q;

  wcs_host_regs #(.AW(AW)) u_regs (
    .clk, .rst, .bus_wr, .bus_sel, .bus_wdata,
    .sts_load_i, .sts_uidx_i, .sts_err_i,
    .ctrl_q, .addr_q, .data_q, .status_q,
    .st_we, .st_addr
  );

  wcs_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
    .clk,
    .we(st_we), .waddr(st_addr), .wdata(data_q),
    .raddr_a(st_addr), .rdata_a(ram_q),
    .raddr_b(seq_addr_i), .rdata_b(seq_data_o)
  );

  wcs_readback u_rb (
    .clk, .rst, .bus_rd, .bus_sel, .seq_ready_i,
    .ctrl_q, .status_q, .addr_q, .data_q, .ram_q,
    .bus_rdata
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= seq_ready_i && ctrl_q[CB_IIE];
  end

  assign ctrl_o    = ctrl_q;
  assign eng_rst_o = ctrl_q[CB_RST];
  assign irq_in_o  = irq_q;
endmodule

// File: rtl/wcs_checker.sv
module wcs_checker (
  input logic        clk,
  input logic        rst,
  input logic        bus_wr,
  input logic [1:0]  bus_sel,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic        seq_ready_i,
  input logic        sts_load_i,
  input logic [15:0] ctrl_o,
  input logic        eng_rst_o,
  input logic        irq_in_o,
  input logic        st_we,
  input logic [15:0] status_q
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (bus_rdata == 16'h0 && ctrl_o == 16'h0 && !irq_in_o && !eng_rst_o));

  p_strobe_rise_r5: assert property (@(posedge clk) disable iff (rst)
    st_we |-> !ctrl_o[13]);

  p_strobe_gated_r7: assert property (@(posedge clk) disable iff (rst)
    st_we |=> (ctrl_o[13] && ctrl_o[10] && !ctrl_o[15]));

  p_engine_reset_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel == 2'd0 && bus_wdata[14]) |=> eng_rst_o);

  p_irq_follow_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_in_o == ($past(seq_ready_i) && $past(ctrl_o[6]))));

  p_status_post_r11: assert property (@(posedge clk) disable iff (rst)
    (sts_load_i && !eng_rst_o) |=> status_q[7]);
endmodule

bind wcs_top wcs_checker u_chk (
  .clk, .rst, .bus_wr, .bus_sel, .bus_wdata, .bus_rdata,
  .seq_ready_i, .sts_load_i, .ctrl_o, .eng_rst_o, .irq_in_o,
  .st_we, .status_q
);

// File: tb/wcs_top_bench.sv
module wcs_top_bench;
  localparam int DEPTH = 1024;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic seq_ready_i = 1'b0, sts_load_i = 1'b0;
  logic [2:0] sts_uidx_i = 3'd0;
  logic [7:0] sts_err_i = 8'h0;
  logic [AW-1:0] seq_addr_i = '0;
  logic [15:0] seq_data_o, ctrl_o;
  logic eng_rst_o, irq_in_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wcs_top #(.DEPTH(DEPTH)) u_wcs_top (
    .clk, .rst, .bus_wr, .bus_rd, .bus_sel, .bus_wdata, .bus_rdata,
    .seq_ready_i, .sts_load_i, .sts_uidx_i, .sts_err_i,
    .seq_addr_i, .seq_data_o, .ctrl_o, .eng_rst_o, .irq_in_o
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic hrd(input logic [1:0] sel, output logic [15:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel = sel;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic load_word(input logic [15:0] a, input logic [15:0] d);
    hwr(2'd0, 16'h0000);
    hwr(2'd2, a);
    hwr(2'd3, d);
    hwr(2'd0, 16'h0400);
    hwr(2'd0, 16'h2400);
  endtask

  task automatic read_word(input logic [15:0] a, output logic [15:0] v);
    hwr(2'd0, 16'h0000);
    hwr(2'd2, a);
    hwr(2'd0, 16'h0400);
    hrd(2'd3, v);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 rdata", bus_rdata, 16'h0);
    chk("R1 ctrl_o", ctrl_o, 16'h0);
    chk("R1 irq/engrst", {14'h0, irq_in_o, eng_rst_o}, 16'h0);
    hrd(2'd0, v);
    chk("R1 ctrl read", v, 16'h0);
  endtask

  task automatic t_ctrl_bits;
    logic [15:0] v;
    hwr(2'd0, 16'hFFFF);
    chk("R2 ctrl_o mask", ctrl_o, 16'hEF4D);
    hrd(2'd0, v);
    chk("R2 ctrl read", v, 16'hEF4D);
    hwr(2'd0, 16'h0000);
    hwr(2'd0, 16'h8800);
    chk("R2 run+arb", ctrl_o, 16'h8800);
    hwr(2'd0, 16'h0000);
    hrd(2'd2, v);
    chk("R2 addr read", v, 16'h0000);
  endtask

  task automatic t_write_read;
    logic [15:0] v;
    load_word(16'd7, 16'h1234);
    load_word(16'd8, 16'hA5C3);
    read_word(16'd7, v);
    chk("R3 word7", v, 16'h1234);
    read_word(16'd8, v);
    chk("R4 word8", v, 16'hA5C3);
    hwr(2'd0, 16'h0000);
    hwr(2'd3, 16'h5A5A);
    hrd(2'd3, v);
    chk("R4 data reg when unselected", v, 16'h5A5A);
  endtask

  task automatic t_no_rewrite;
    logic [15:0] v;
    load_word(16'd9, 16'h1111);
    hwr(2'd3, 16'h2222);
    hwr(2'd0, 16'h2400);
    read_word(16'd9, v);
    chk("R5 held strobe", v, 16'h1111);
  endtask

  task automatic t_no_select;
    logic [15:0] v;
    hwr(2'd0, 16'h0000);
    hwr(2'd2, 16'd7);
    hwr(2'd3, 16'hDEAD);
    hwr(2'd0, 16'h2000);
    read_word(16'd7, v);
    chk("R6 no select", v, 16'h1234);
  endtask

  task automatic t_run_block;
    logic [15:0] v;
    hwr(2'd0, 16'h0000);
    hwr(2'd2, 16'd8);
    hwr(2'd3, 16'hBEEF);
    hwr(2'd0, 16'h8400);
    hwr(2'd0, 16'hA400);
    read_word(16'd8, v);
    chk("R7 run blocks", v, 16'hA5C3);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    load_word(16'(DEPTH + 5), 16'hC0DE);
    read_word(16'd5, v);
    chk("R8 alias low", v, 16'hC0DE);
    load_word(16'd6, 16'h0F0F);
    read_word(16'(DEPTH + 6), v);
    chk("R8 alias high", v, 16'h0F0F);
  endtask

  task automatic t_seq_port;
    @(negedge clk);
    seq_addr_i = AW'(7);
    @(negedge clk);
    chk("R12 seq word7", seq_data_o, 16'h1234);
    seq_addr_i = AW'(5);
    @(negedge clk);
    chk("R12 seq word5", seq_data_o, 16'hC0DE);
  endtask

  task automatic t_status;
    logic [15:0] v;
    hwr(2'd0, 16'h0000);
    @(negedge clk);
    sts_load_i = 1'b1; sts_uidx_i = 3'd5; sts_err_i = 8'hA3;
    @(negedge clk);
    sts_load_i = 1'b0;
    hrd(2'd1, v);
    chk("R11 post", v, 16'hA385);
    hwr(2'd1, 16'h0040);
    hrd(2'd1, v);
    chk("R11 clear rout set oie", v, 16'hA345);
    hwr(2'd1, 16'h00C0);
    hrd(2'd1, v);
    chk("R11 write 1 no set", v, 16'hA345);
    hwr(2'd0, 16'h4000);
    chk("R9 eng_rst high", {15'h0, eng_rst_o}, 16'h1);
    hrd(2'd1, v);
    chk("R9 status held zero", v, 16'h0000);
    hwr(2'd0, 16'h0000);
    chk("R9 eng_rst released", {15'h0, eng_rst_o}, 16'h0);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    hwr(2'd0, 16'h0040);
    @(negedge clk);
    chk("R10 no ready", {15'h0, irq_in_o}, 16'h0);
    seq_ready_i = 1'b1;
    @(negedge clk);
    chk("R10 ready+iie", {15'h0, irq_in_o}, 16'h1);
    hrd(2'd0, v);
    chk("R2 ready bit read", v, 16'h00C0);
    hwr(2'd0, 16'h0000);
    @(negedge clk);
    chk("R10 iie off", {15'h0, irq_in_o}, 16'h0);
    seq_ready_i = 1'b0;
  endtask

  task automatic t_hold;
    logic [15:0] v;
    hwr(2'd2, 16'h0123);
    hrd(2'd2, v);
    hwr(2'd2, 16'h0456);
    repeat (2) @(negedge clk);
    chk("R13 rdata holds", bus_rdata, 16'h0123);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl_bits();
    t_write_read();
    t_no_rewrite();
    t_no_select();
    t_run_block();
    t_wrap();
    t_seq_port();
    t_status();
    t_irq();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule